// File: doc/BRIEF.md
# Scan Chain Integrity Tester

This block tests the shift path of one or more scan chains before any combinational test vectors go through them. When a start pulse arrives it holds the shared test-control line in shift mode. It then drives every chain's serial input with the repeating stimulus 0,0,1,1. Because the stimulus has period four, each flip-flop in a chain sees a rising, a falling, a held-low and a held-high transition.

For each chain the block models what should come out of the serial output: the stimulus, delayed by that chain's length. A chain's comparison turns on only after its own length in cycles has passed. This way, stale contents flushed out of the chain cannot raise a false error. The run lasts the longest chain length plus four cycles, so even the longest chain presents all four stimulus phases at its output. Shorter chains are compared over a longer window.

Each chain has its own sticky error flag. A done flag is raised when the run ends. Chain lengths are compile-time parameters given as an array.

Top module: `scan_chain_checker`

## Requirements
- R1: After reset, busy_o=0, done_o=0, all err_o bits are 0, scan_tc_o=1 (functional mode) and every scan_in_o bit is 0.
- R2: A start_i pulse sampled while idle starts a run in the next cycle. busy_o goes to 1, and done_o and all err_o bits go to 0.
- R3: In run cycle k (k=0 is the first cycle with busy_o=1), every scan_in_o bit equals bit 1 of k, which gives 0,0,1,1 repeating.
- R4: A run lasts exactly max(CHAIN_LEN)+4 cycles. Afterwards busy_o=0, scan_tc_o=1 and done_o=1, and done_o holds until the next start.
- R5: In run cycle k with k >= CHAIN_LEN[c], scan_out_i[c] is compared with bit 1 of (k - CHAIN_LEN[c]). A mismatch sets err_o[c].
- R6: A mismatch on scan_out_i[c] in a run cycle k < CHAIN_LEN[c] has no effect on err_o[c].
- R7: err_o bits are sticky. Each bit is set only by its own chain and holds until the next accepted start.
- R8: A start_i pulse during a run is ignored. The run length and the error flags are unaffected.
- R9: One test-control output, scan_tc_o, serves all chains. It is 0 (shift) exactly during a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| scan_out_i | input | NUM_CHAINS | Serial outputs of the chains |
| scan_in_o | output | NUM_CHAINS | Serial stimulus to each chain |
| scan_tc_o | output | 1 | Shared test control, 0 = shift |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished |
| err_o | output | NUM_CHAINS | Sticky per-chain mismatch flags |

## Verification
The stimulus bit for run cycle k is present during that same cycle. A chain of length L returns it in cycle k+L, and that is where the compare happens. A mismatch there shows on err_o one edge later. done_o and the drop of busy_o appear one edge after the last run cycle. The bench samples every output at the falling edge. It keeps its own run-cycle count, which it derives from busy_o. It uses that count to inject single-cycle faults exactly at the compare-window boundaries and to read the pattern for each cycle.

// File: rtl/scan_chk_pkg.sv
package scan_chk_pkg;
  localparam int unsigned PAT_PERIOD = 4;

  // stimulus phase -> bit: 0,0,1,1
  function automatic logic pat_bit(input logic [1:0] phase);
    return phase[1];
  endfunction
endpackage

// File: rtl/scan_chk_ctrl.sv
module scan_chk_ctrl #(
  parameter int unsigned RUN_LEN = 12,
  localparam int unsigned CNT_W  = $clog2(RUN_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             clr_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

  logic             busy_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept;

  assign accept = start_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign clr_o  = accept;
  assign cnt_o  = cnt_q;

  AST_RUN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cnt_q != LAST |=> busy_q && cnt_q == $past(cnt_q) + 1'b1); // R8
  AST_DONE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(busy_q) && $past(cnt_q) == LAST); // R4
  AST_IDLE_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cnt_q == LAST && !start_i |=> !busy_q && done_q); // R4
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q <= LAST); // R4
endmodule

// File: rtl/scan_chk_patgen.sv
module scan_chk_patgen
  import scan_chk_pkg::*;
#(
  parameter int unsigned NUM_CHAINS = 3,
  parameter int unsigned CNT_W      = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  busy_i,
  input  logic [CNT_W-1:0]      cnt_i,
  output logic [NUM_CHAINS-1:0] scan_in_o,
  output logic                  scan_tc_o
);
  logic stim;

  assign stim      = busy_i ? pat_bit(cnt_i[1:0]) : 1'b0;
  assign scan_tc_o = !busy_i;

  for (genvar g = 0; g < NUM_CHAINS; g++) begin : g_fan
    assign scan_in_o[g] = stim;
  end

  AST_PATTERN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && cnt_i >= CNT_W'(PAT_PERIOD) |-> scan_in_o == $past(scan_in_o, 4)); // R3
  AST_PATTERN_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> scan_in_o == '0); // R3
endmodule

// File: rtl/scan_chk_mon.sv
module scan_chk_mon
  import scan_chk_pkg::*;
#(
  parameter int unsigned LEN   = 5,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             busy_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             scan_out_i,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] LEN_C = CNT_W'(LEN);

  logic             err_q;
  logic             armed;
  logic [CNT_W-1:0] lag;
  logic             expect_bit;

  assign armed      = busy_i && (cnt_i >= LEN_C);
  assign lag        = cnt_i - LEN_C;
  assign expect_bit = pat_bit(lag[1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
    end else if (clr_i) begin
      err_q <= 1'b0;
    end else if (armed && (scan_out_i != expect_bit)) begin
      err_q <= 1'b1;
    end
  end

  assign err_o = err_q;

  AST_NO_EARLY_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(busy_i) && $past(cnt_i) >= LEN_C); // R6
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q && !clr_i |=> err_q); // R7
  AST_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !err_q); // R2
endmodule

// File: rtl/scan_chain_checker.sv
module scan_chain_checker #(
  parameter int unsigned NUM_CHAINS            = 3,
  parameter int unsigned CHAIN_LEN [NUM_CHAINS] = '{5, 8, 3}
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [NUM_CHAINS-1:0] scan_out_i,
  output logic [NUM_CHAINS-1:0] scan_in_o,
  output logic                  scan_tc_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [NUM_CHAINS-1:0] err_o
);
  function automatic int unsigned longest();
    int unsigned m = 1;
    for (int i = 0; i < NUM_CHAINS; i++)
      if (CHAIN_LEN[i] > m) m = CHAIN_LEN[i];
    return m;
  endfunction

  localparam int unsigned MAX_LEN = longest();
  localparam int unsigned RUN_LEN = MAX_LEN + scan_chk_pkg::PAT_PERIOD;
  localparam int unsigned CNT_W   = $clog2(RUN_LEN);

  logic             busy, clr;
  logic [CNT_W-1:0] cnt;

  scan_chk_ctrl #(.RUN_LEN(RUN_LEN)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .busy_o  (busy),
    .done_o  (done_o),
    .clr_o   (clr),
    .cnt_o   (cnt)
  );

  scan_chk_patgen #(.NUM_CHAINS(NUM_CHAINS), .CNT_W(CNT_W)) u_pat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (busy),
    .cnt_i     (cnt),
    .scan_in_o (scan_in_o),
    .scan_tc_o (scan_tc_o)
  );

  for (genvar g = 0; g < NUM_CHAINS; g++) begin : g_mon
    scan_chk_mon #(.LEN(CHAIN_LEN[g]), .CNT_W(CNT_W)) u_mon (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (clr),
      .busy_i     (busy),
      .cnt_i      (cnt),
      .scan_out_i (scan_out_i[g]),
      .err_o      (err_o[g])
    );
  end

  assign busy_o = busy;

  AST_TC_TRACKS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !scan_tc_o); // R9
  AST_NO_ERR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |=> err_o == $past(err_o) || $past(clr)); // R7
endmodule

// File: tb/scan_chain_checker_tb.sv
module scan_chain_checker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 3;
  localparam int unsigned LEN [NC] = '{5, 8, 3};
  localparam int RUN_LEN = 12;

  typedef struct packed {
    logic [1:0] chain;
    logic [2:0] mode;   // 0 none, 1 stuck0, 2 stuck1, 3 extra stage, 4 flip at cyc
    logic [3:0] cyc;
    logic [2:0] exp_err;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 3'd0, 4'd0,  3'b000},
    '{2'd0, 3'd1, 4'd0,  3'b001},
    '{2'd1, 3'd2, 4'd0,  3'b010},
    '{2'd2, 3'd3, 4'd0,  3'b100},
    '{2'd1, 3'd4, 4'd7,  3'b000},
    '{2'd1, 3'd4, 4'd8,  3'b010},
    '{2'd2, 3'd4, 4'd11, 3'b100},
    '{2'd0, 3'd4, 4'd4,  3'b000}
  };

  logic clk = 0, rst_ni = 0, start = 0;
  logic [NC-1:0] scan_out, scan_in, err;
  logic tc, busy, done;
  logic [15:0] chain_q [NC];
  int run_cyc = 0;
  logic [1:0] f_chain = 0;
  logic [2:0] f_mode = 0;
  logic [3:0] f_cyc = 0;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_chain_checker #(.NUM_CHAINS(NC), .CHAIN_LEN(LEN)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .scan_out_i(scan_out),
    .scan_in_o(scan_in), .scan_tc_o(tc), .busy_o(busy), .done_o(done), .err_o(err)
  );

  always @(posedge clk) begin
    for (int c = 0; c < NC; c++)
      if (!tc) chain_q[c] <= {chain_q[c][14:0], scan_in[c]};
    run_cyc <= busy ? run_cyc + 1 : 0;
  end

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      logic b;
      b = (f_mode == 3 && f_chain == c) ? chain_q[c][LEN[c]] : chain_q[c][LEN[c]-1];
      if (f_chain == c) begin
        if (f_mode == 1) b = 1'b0;
        if (f_mode == 2) b = 1'b1;
        if (f_mode == 4 && busy && run_cyc == int'(f_cyc)) b = ~b;
      end
      scan_out[c] = b;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // one run; mid_start >= 0 pulses start during that run cycle
  task automatic run(input logic [2:0] exp_err, input int mid_start);
    int k;
    bit pat_ok, tc_ok;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(busy && err == 0 && !done, "R2", {busy, done, err}, 3'b100 << 2);
    k = 0; pat_ok = 1; tc_ok = 1;
    while (busy) begin
      if (scan_in != {NC{k[1]}}) pat_ok = 0;
      if (tc) tc_ok = 0;
      start = (k == mid_start);
      @(negedge clk);
      start = 0;
      k++;
      if (k > 100) begin chk(0, "R4 watchdog", k, RUN_LEN); summary(); end
    end
    chk(pat_ok, "R3", pat_ok, 1);
    chk(tc_ok, "R9", tc_ok, 1);
    chk(k == RUN_LEN, "R4", k, RUN_LEN);
    chk(done && tc && scan_in == 0, "R4", {done, tc}, 3);
    chk(err == exp_err, "R5", err, exp_err);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    for (int c = 0; c < NC; c++) chain_q[c] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && err == 0 && tc && scan_in == 0, "R1", {busy, done, err}, 0);
    rst_ni = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      f_chain = TBL[i].chain; f_mode = TBL[i].mode; f_cyc = TBL[i].cyc;
      run(TBL[i].exp_err, -1);
    end

    // R7: flags hold after end, per chain
    f_chain = 1; f_mode = 1;
    run(3'b010, -1);
    f_mode = 0;
    repeat (4) @(negedge clk);
    chk(err == 3'b010 && done, "R7", err, 3'b010);

    // R6: glitch on shortest chain just before its window
    f_chain = 2; f_mode = 4; f_cyc = 2;
    run(3'b000, -1);
    // R5: glitch on first compared cycle
    f_cyc = 3;
    run(3'b100, -1);

    // R8: start mid-run ignored, flags stay
    f_chain = 0; f_mode = 4; f_cyc = 5;
    run(3'b001, 7);

    // R2: next clean run clears flags
    f_mode = 0;
    run(3'b000, -1);

    // R1: async reset mid-run
    f_chain = 0; f_mode = 1;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    repeat (9) @(negedge clk);
    rst_ni = 0;
    @(negedge clk);
    chk(!busy && !done && err == 0 && tc, "R1", {busy, done, err}, 0);
    rst_ni = 1;
    f_mode = 0;
    @(negedge clk);
    summary();
  end
endmodule